// File: doc/BRIEF.md
# Stop-Mode Standby and Wake-Up Sequencer

This block sequences the deepest low-power state of a small microcontroller core. When software writes the stop-request bit, the block checks for pending interrupts. If none is pending, it turns off the oscillator enable and closes the CPU clock gate. It also puts the external pins into either a held state or a floating state, chosen by a pin-select bit in the same write. Register and memory contents are kept because the clocks stop and nothing is cleared.

The sequencer leaves the stopped state in only two ways: a chip reset request, or a qualifying external interrupt. The interrupt must carry a priority level above the lowest level, and it wakes the block whatever the CPU interrupt mask is. After the oscillator restarts, a parameterized counter stands in for the oscillation settling time, and the CPU clock stays gated until it expires. A reset skips this wait only when the block is built without power-on reset. The core learns how the stop ended from a one-cycle pulse and a cause flag. The flag tells it to resume after the stop instruction, or to take the interrupt, or to run reset processing.

Top module: `stop_seq_ctrl`

## Requirements
- R1: A write with `cfg_wr`=1 and `cfg_stop`=1, while no interrupt is pending, enters stop on the next clock edge: `osc_en` and `cpu_clk_en` both read 0 in the following cycle.
- R2: If any peripheral or external request is high in the write cycle, a stop write is dropped. The block stays running, and it stays running after the requests clear.
- R3: During stop and settling, `cfg_pin_float`=0 drives `pin_hold`=1 and `cfg_pin_float`=1 drives `pin_float`=1. The two are never high together, and both are low whenever `cpu_clk_en` is 1.
- R4: While stopped, peripheral requests and external requests at level 2'b11 do not wake the block: `osc_en` stays 0.
- R5: While stopped, an external request at level 2'b00, 2'b01 or 2'b10 raises `osc_en` in the next cycle, with `cpu_clk_en` still 0.
- R6: After an interrupt wake, `cpu_clk_en` stays 0 for exactly STAB_CYCLES cycles. It then rises together with a single-cycle `wake_pulse` and `wake_by_reset`=0.
- R7: With HAS_POR=1, a reset request while stopped starts the same STAB_CYCLES settling wait. The wait ends in `wake_pulse` with `wake_by_reset`=1.
- R8: With HAS_POR=0, a reset request while stopped returns to running in the next cycle, with `wake_pulse`=1 and `wake_by_reset`=1.
- R9: A reset request while stopped releases `pin_hold` and `pin_float` in the next cycle, even while settling continues.
- R10: When a reset request and a qualifying external request arrive in the same stopped cycle, the reset wins: the wake ends with `wake_by_reset`=1.
- R11: A write with `cfg_stop`=0 has no effect. Writes made while stopped are ignored and do not change the pin mode.
- R12: After `rst_n`, the block is running: `osc_en`=1, `cpu_clk_en`=1, both pin controls are 0, and `wake_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the sequencer and the settling counter |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_wr | input | 1 | Write strobe of the standby control field |
| cfg_stop | input | 1 | Stop-request bit carried by the write |
| cfg_pin_float | input | 1 | Pin-state select: 0 holds the pins, 1 floats them |
| periph_irq | input | NUM_PERIPH | Pending peripheral interrupt requests |
| ext_irq | input | NUM_EXT | Pending external interrupt requests |
| ext_irq_lvl | input | 2*NUM_EXT | Two-bit priority level per external request; lower value means higher priority |
| reset_req | input | 1 | Chip reset request, acting as a wake source |
| osc_en | output | 1 | Oscillator enable, low only while stopped |
| cpu_clk_en | output | 1 | CPU clock gate, high only while running |
| pin_hold | output | 1 | Pins latched at their last state |
| pin_float | output | 1 | Pins released to high impedance (pull-ups read high) |
| wake_pulse | output | 1 | One-cycle pulse when the core is released from stop |
| wake_by_reset | output | 1 | Cause of the last release: 1 reset, 0 interrupt |

## Verification
A wrong state here shows within one cycle on the clock and oscillator outputs. A missed stop leaves `cpu_clk_en` high. A false wake raises `osc_en`. A settling count that is off by one moves the rise of `cpu_clk_en` and `wake_pulse` by exactly that many cycles. A stale pin mode or a lost wake cause only shows up later: at the release cycle through `wake_by_reset`, or through pin controls that stay up while running. The directed scenarios therefore sample every cycle of the settling window and the release cycle itself.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

  localparam int LVL_W = 2;

  typedef logic [LVL_W-1:0] irq_lvl_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PIN_FREE  = 2'd0,
    PIN_HOLD  = 2'd1,
    PIN_FLOAT = 2'd2
  } pin_mode_e;

  typedef enum logic {
    CAUSE_IRQ   = 1'b0,
    CAUSE_RESET = 1'b1
  } wake_cause_e;

  // Only the all-ones (lowest priority) level is barred from waking the core.
  function automatic logic lvl_can_wake(irq_lvl_t lvl);
    return lvl != {LVL_W{1'b1}};
  endfunction

  function automatic pin_mode_e pin_mode_for(logic float_bit);
    return float_bit ? PIN_FLOAT : PIN_HOLD;
  endfunction

  // Counter width able to hold values 0 .. cycles-1.
  function automatic int stab_cnt_w(int cycles);
    return (cycles < 2) ? 1 : $clog2(cycles);
  endfunction

endpackage

// File: rtl/stop_seq_entry_gate.sv
module stop_seq_entry_gate
  import stop_seq_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int NUM_EXT    = 4
) (
  input  logic                  in_run,
  input  logic                  wr,
  input  logic                  stop_bit,
  input  logic                  float_bit,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  input  logic [NUM_EXT-1:0]    ext_irq,
  output logic                  enter_stop,
  output logic                  stop_dropped,
  output pin_mode_e             entry_mode
);

  logic any_pending;
  logic stop_written;

  assign any_pending  = (|periph_irq) | (|ext_irq);
  // Writes are only seen while the core is clocked.
  assign stop_written = in_run & wr & stop_bit;
  assign enter_stop   = stop_written & ~any_pending;
  assign stop_dropped = stop_written & any_pending;
  assign entry_mode   = pin_mode_for(float_bit);

endmodule

// File: rtl/stop_seq_wake_detect.sv
module stop_seq_wake_detect
  import stop_seq_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic                     armed,
  input  logic [NUM_EXT-1:0]       ext_irq,
  input  logic [NUM_EXT*LVL_W-1:0] ext_irq_lvl,
  output logic                     wake_hit
);

  logic [NUM_EXT-1:0] hit_vec;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_src
    assign hit_vec[i] = ext_irq[i] & lvl_can_wake(ext_irq_lvl[i*LVL_W +: LVL_W]);
  end

  // CPU mask and current level are deliberately not inputs here.
  assign wake_hit = armed & (|hit_vec);

endmodule

// File: rtl/stop_seq_stab_timer.sv
module stop_seq_stab_timer
  import stop_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  localparam int            CW   = stab_cnt_w(STAB_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run & ~start & (cnt_q == LAST);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
  import stop_seq_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int NUM_EXT     = 4,
  parameter int STAB_CYCLES = 16,
  parameter bit HAS_POR     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic                     cfg_stop,
  input  logic                     cfg_pin_float,
  input  logic [NUM_PERIPH-1:0]    periph_irq,
  input  logic [NUM_EXT-1:0]       ext_irq,
  input  logic [NUM_EXT*LVL_W-1:0] ext_irq_lvl,
  input  logic                     reset_req,
  output logic                     osc_en,
  output logic                     cpu_clk_en,
  output logic                     pin_hold,
  output logic                     pin_float,
  output logic                     wake_pulse,
  output logic                     wake_by_reset
);

  seq_state_e  state_q, state_d;
  pin_mode_e   pin_mode_q, pin_mode_d;
  wake_cause_e cause_q, cause_d;
  logic        pulse_q, pulse_d;
  logic        by_reset_q, by_reset_d;

  // Named internal events.
  logic      enter_stop;
  logic      stop_dropped;
  pin_mode_e entry_mode;
  logic      ext_wake_hit;
  logic      stab_start;
  logic      stab_done;
  logic      in_stop;
  logic      in_stab;

  assign in_stop = (state_q == ST_STOP);
  assign in_stab = (state_q == ST_STAB);

  stop_seq_entry_gate #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_EXT    (NUM_EXT)
  ) u_entry (
    .in_run       (state_q == ST_RUN),
    .wr           (cfg_wr),
    .stop_bit     (cfg_stop),
    .float_bit    (cfg_pin_float),
    .periph_irq   (periph_irq),
    .ext_irq      (ext_irq),
    .enter_stop   (enter_stop),
    .stop_dropped (stop_dropped),
    .entry_mode   (entry_mode)
  );

  stop_seq_wake_detect #(
    .NUM_EXT (NUM_EXT)
  ) u_wake (
    .armed       (in_stop),
    .ext_irq     (ext_irq),
    .ext_irq_lvl (ext_irq_lvl),
    .wake_hit    (ext_wake_hit)
  );

  stop_seq_stab_timer #(
    .STAB_CYCLES (STAB_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stab_start),
    .run   (in_stab),
    .done  (stab_done)
  );

  always_comb begin
    state_d    = state_q;
    pin_mode_d = pin_mode_q;
    cause_d    = cause_q;
    pulse_d    = 1'b0;
    by_reset_d = by_reset_q;
    stab_start = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (enter_stop) begin
          state_d    = ST_STOP;
          pin_mode_d = entry_mode;
        end
      end
      ST_STOP: begin
        if (reset_req) begin
          pin_mode_d = PIN_FREE;
          cause_d    = CAUSE_RESET;
          if (HAS_POR) begin
            state_d    = ST_STAB;
            stab_start = 1'b1;
          end else begin
            state_d    = ST_RUN;
            pulse_d    = 1'b1;
            by_reset_d = 1'b1;
          end
        end else if (ext_wake_hit) begin
          state_d    = ST_STAB;
          cause_d    = CAUSE_IRQ;
          stab_start = 1'b1;
        end
      end
      ST_STAB: begin
        if (reset_req) begin
          pin_mode_d = PIN_FREE;
          cause_d    = CAUSE_RESET;
        end
        if ((reset_req && !HAS_POR) || stab_done) begin
          state_d    = ST_RUN;
          pin_mode_d = PIN_FREE;
          pulse_d    = 1'b1;
          by_reset_d = reset_req || (cause_q == CAUSE_RESET);
        end
      end
      default: begin
        state_d    = ST_RUN;
        pin_mode_d = PIN_FREE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      pin_mode_q <= PIN_FREE;
      cause_q    <= CAUSE_IRQ;
      pulse_q    <= 1'b0;
      by_reset_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pin_mode_q <= pin_mode_d;
      cause_q    <= cause_d;
      pulse_q    <= pulse_d;
      by_reset_q <= by_reset_d;
    end
  end

  assign osc_en        = (state_q != ST_STOP);
  assign cpu_clk_en    = (state_q == ST_RUN);
  assign pin_hold      = (pin_mode_q == PIN_HOLD);
  assign pin_float     = (pin_mode_q == PIN_FLOAT);
  assign wake_pulse    = pulse_q;
  assign wake_by_reset = by_reset_q;

  assert_drop_when_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_dropped |=> cpu_clk_en);

  assert_pins_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_hold && pin_float));

  assert_pins_free_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> !(pin_hold || pin_float));

  assert_no_false_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !ext_wake_hit && !reset_req) |=> !osc_en);

  assert_gate_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stab && !stab_done && !reset_req) |=> !cpu_clk_en);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_np_reset_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_POR && in_stop && reset_req) |=> (wake_pulse && wake_by_reset));

  assert_reset_frees_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && reset_req) |=> !(pin_hold || pin_float));

  assert_reset_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && reset_req && ext_wake_hit) |=> (cause_q == CAUSE_RESET));

endmodule

// File: tb/stop_seq_ctrl_tb.sv
module stop_seq_ctrl_tb;

  localparam int NP   = 4;
  localparam int NE   = 4;
  localparam int STAB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0, cfg_stop = 1'b0, cfg_pin_float = 1'b0;
  logic [NP-1:0] periph_irq = '0;
  logic [NE-1:0] ext_irq = '0;
  logic [2*NE-1:0] ext_irq_lvl = '1;
  logic          reset_req = 1'b0;

  logic osc_en, cpu_clk_en, pin_hold, pin_float, wake_pulse, wake_by_reset;
  logic np_osc_en, np_cpu_clk_en, np_pin_hold, np_pin_float, np_wake_pulse, np_wake_by_reset;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  stop_seq_ctrl #(.NUM_PERIPH(NP), .NUM_EXT(NE), .STAB_CYCLES(STAB), .HAS_POR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_stop(cfg_stop),
    .cfg_pin_float(cfg_pin_float), .periph_irq(periph_irq), .ext_irq(ext_irq),
    .ext_irq_lvl(ext_irq_lvl), .reset_req(reset_req), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .pin_hold(pin_hold), .pin_float(pin_float),
    .wake_pulse(wake_pulse), .wake_by_reset(wake_by_reset));

  stop_seq_ctrl #(.NUM_PERIPH(NP), .NUM_EXT(NE), .STAB_CYCLES(STAB), .HAS_POR(1'b0)) u_dut_np (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_stop(cfg_stop),
    .cfg_pin_float(cfg_pin_float), .periph_irq(periph_irq), .ext_irq(ext_irq),
    .ext_irq_lvl(ext_irq_lvl), .reset_req(reset_req), .osc_en(np_osc_en),
    .cpu_clk_en(np_cpu_clk_en), .pin_hold(np_pin_hold), .pin_float(np_pin_float),
    .wake_pulse(np_wake_pulse), .wake_by_reset(np_wake_by_reset));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ext(input int idx, input logic [1:0] lvl);
    ext_irq = '0;
    ext_irq_lvl = '1;
    ext_irq[idx] = 1'b1;
    ext_irq_lvl[idx*2 +: 2] = lvl;
  endtask

  task automatic clr_ext();
    ext_irq = '0;
    ext_irq_lvl = '1;
  endtask

  // R12: state right after the block reset
  task automatic t_reset_state();
    chk("R12 osc_en", osc_en, 1);
    chk("R12 cpu_clk_en", cpu_clk_en, 1);
    chk("R12 pins", {pin_hold, pin_float}, 0);
    chk("R12 wake_pulse", wake_pulse, 0);
  endtask

  // R1, R3: stop entry with the chosen pin mode
  task automatic t_enter_stop(input logic flt);
    cfg_wr = 1'b1; cfg_stop = 1'b1; cfg_pin_float = flt;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_stop = 1'b0; cfg_pin_float = 1'b0;
    chk("R1 osc_en off", osc_en, 0);
    chk("R1 cpu_clk_en off", cpu_clk_en, 0);
    chk("R3 pin_hold", pin_hold, int'(!flt));
    chk("R3 pin_float", pin_float, int'(flt));
  endtask

  // R11: write with stop bit clear
  task automatic t_write_no_stop();
    cfg_wr = 1'b1; cfg_stop = 1'b0; cfg_pin_float = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_pin_float = 1'b0;
    @(negedge clk);
    chk("R11 no stop from cleared bit", cpu_clk_en, 1);
    chk("R11 pins untouched", {pin_hold, pin_float}, 0);
  endtask

  // R2: stop write dropped while a request is pending
  task automatic t_drop_pending();
    periph_irq = 4'b0100;
    cfg_wr = 1'b1; cfg_stop = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_stop = 1'b0;
    chk("R2 periph pending drops stop", cpu_clk_en, 1);
    periph_irq = '0;
    repeat (3) @(negedge clk);
    chk("R2 no deferred stop", osc_en, 1);
    set_ext(1, 2'b11);
    cfg_wr = 1'b1; cfg_stop = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_stop = 1'b0;
    clr_ext();
    chk("R2 ext pending drops stop", cpu_clk_en, 1);
    @(negedge clk);
    chk("R2 still running", osc_en, 1);
  endtask

  // R4: non-qualifying sources while stopped
  task automatic t_no_false_wake();
    periph_irq = '1;
    @(negedge clk);
    chk("R4 periph no wake", osc_en, 0);
    periph_irq = '0;
    set_ext(3, 2'b11);
    repeat (2) @(negedge clk);
    chk("R4 level 11 no wake", osc_en, 0);
    clr_ext();
    @(negedge clk);
    chk("R4 still stopped", cpu_clk_en, 0);
  endtask

  // R11: writes while stopped are ignored
  task automatic t_write_in_stop(input logic held_float);
    cfg_wr = 1'b1; cfg_stop = 1'b1; cfg_pin_float = !held_float;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_stop = 1'b0; cfg_pin_float = 1'b0;
    chk("R11 pin mode kept", pin_float, int'(held_float));
    chk("R11 still stopped", osc_en, 0);
  endtask

  // R5, R6: interrupt wake and settling window
  task automatic t_irq_wake(input logic [1:0] lvl, input logic flt);
    set_ext(2, lvl);
    @(negedge clk);
    clr_ext();
    chk("R5 osc restarts", osc_en, 1);
    chk("R5 cpu gated", cpu_clk_en, 0);
    chk("R3 pins kept in settling", {pin_hold, pin_float}, flt ? 1 : 2);
    for (int i = 1; i < STAB; i++) begin
      @(negedge clk);
      chk("R6 gated during settling", cpu_clk_en, 0);
    end
    @(negedge clk);
    chk("R6 cpu clock released", cpu_clk_en, 1);
    chk("R6 wake pulse", wake_pulse, 1);
    chk("R6 cause interrupt", wake_by_reset, 0);
    chk("R3 pins freed", {pin_hold, pin_float}, 0);
    @(negedge clk);
    chk("R6 pulse single", wake_pulse, 0);
  endtask

  // R7, R8, R9: reset while stopped
  task automatic t_reset_in_stop();
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    chk("R9 pins freed at once", {pin_hold, pin_float}, 0);
    chk("R7 osc restarts", osc_en, 1);
    chk("R7 cpu gated", cpu_clk_en, 0);
    chk("R8 np released", np_cpu_clk_en, 1);
    chk("R8 np pulse", np_wake_pulse, 1);
    chk("R8 np cause reset", np_wake_by_reset, 1);
    chk("R9 np pins freed", {np_pin_hold, np_pin_float}, 0);
    for (int i = 1; i < STAB; i++) begin
      @(negedge clk);
      chk("R7 gated during settling", cpu_clk_en, 0);
    end
    @(negedge clk);
    chk("R7 released", cpu_clk_en, 1);
    chk("R7 pulse", wake_pulse, 1);
    chk("R7 cause reset", wake_by_reset, 1);
    @(negedge clk);
  endtask

  // R10: reset and qualifying interrupt together
  task automatic t_reset_vs_irq();
    reset_req = 1'b1;
    set_ext(0, 2'b00);
    @(negedge clk);
    reset_req = 1'b0;
    clr_ext();
    chk("R10 np cause reset", np_wake_by_reset, 1);
    chk("R10 np pulse", np_wake_pulse, 1);
    repeat (STAB) @(negedge clk);
    chk("R10 pulse", wake_pulse, 1);
    chk("R10 cause reset", wake_by_reset, 1);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_write_no_stop();
    t_drop_pending();
    t_enter_stop(1'b0);
    t_no_false_wake();
    t_write_in_stop(1'b0);
    t_irq_wake(2'b01, 1'b0);
    t_enter_stop(1'b1);
    t_write_in_stop(1'b1);
    t_irq_wake(2'b10, 1'b1);
    t_enter_stop(1'b1);
    t_reset_in_stop();
    t_enter_stop(1'b0);
    t_irq_wake(2'b00, 1'b0);
    t_enter_stop(1'b0);
    t_reset_vs_irq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule